// File: doc/BRIEF.md
# Permuted 3D Index Remap Table Builder

This block turns a programmed three-dimensional shape into a table of element indices. One configuration word gives three axis sizes, a code for the traversal order and three offset flags. After a legal write, a sequencer walks a three-level nested counter over the shape, one step per clock. The permutation code picks which axis moves fastest, which moves next and which moves slowest. At each step the sequencer stores the row-major linear address of the current (x, y, z) point in the table. The walk always produces the full table depth. If the shape has fewer points than that, the walk wraps back to the origin and continues.

A processor-side remap stage reads the table through a registered lookup port: element number in, remapped index out. The table is double-buffered. Lookups made during a rebuild return the previous table, and the new table becomes visible as soon as the rebuild ends. Writes with an undefined order code are rejected with a one-cycle error pulse and change nothing.

Top module: `idx_remap_gen`

## Requirements
- R1: Each axis size is its 7-bit configuration field plus one. X sits in cfg_data[6:0], Y in cfg_data[14:8] and Z in cfg_data[22:16], so sizes run from 1 to 128.
- R2: Each entry holds x + y·X + z·X·Y for the current counter point, truncated to its low 8 bits.
- R3: cfg_data[26:24] selects the order, listed fastest axis first: 0 = X,Y,Z; 1 = X,Z,Y; 2 = Y,X,Z; 3 = Y,Z,X; 4 = Z,X,Y; 5 = Z,Y,X.
- R4: An axis counter that reaches its size returns to zero and carries into the next axis in the selected order. When the whole shape is covered, the walk wraps to the origin and continues until all 128 entries are written, entry k holding the point reached after k steps.
- R5: A write with order code 6 or 7, made while idle, raises cfg_err for exactly one cycle after the write edge. busy stays low, and the table and offs_flags keep their values.
- R6: On a legal write, offs_flags takes {cfg_data[23], cfg_data[15], cfg_data[7]} one edge after the write.
- R7: A legal write made while idle raises busy at the write edge. busy stays high for exactly 128 cycles.
- R8: While busy is high, a lookup returns the table from before the write. After busy falls, lookups return the new table.
- R9: After reset, busy, cfg_err and offs_flags are 0 and every table entry reads 0.
- R10: A configuration write made while busy is high is ignored. It raises no error, leaves offs_flags unchanged and does not alter the table being built.
- R11: lk_data shows the entry addressed by lk_idx one clock edge after lk_idx is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_data | input | 32 | Configuration word (sizes, flags, order code) |
| lk_idx | input | 7 | Element number to look up |
| lk_data | output | 8 | Remapped index, one cycle after lk_idx |
| busy | output | 1 | High while the table is being rebuilt |
| cfg_err | output | 1 | One-cycle pulse after an illegal order code |
| offs_flags | output | 3 | Stored offset flags |

## Verification
The walk is tried with all six order codes on shapes of different proportions. A 4×4×8 identity shape and a 128×1×1 shape check the plain row-major formula. Small shapes such as 3×5×2 and 2×3×4 wrap several times inside 128 entries, so a wrong carry order or wrap point changes many entries. Shapes with sizes near 100 and 128 on the fast axis push the linear address far past 8 bits and expose any error in truncation or multiplier width, and a 1×1×1 shape checks the degenerate all-zero table. Illegal codes, writes during a fill and lookups during a fill show that the previous table stays intact while a rebuild runs.

// File: rtl/idx_remap_pkg.sv
package idx_remap_pkg;

   typedef enum logic [2:0] {
      ORD_XYZ = 3'd0,
      ORD_XZY = 3'd1,
      ORD_YXZ = 3'd2,
      ORD_YZX = 3'd3,
      ORD_ZXY = 3'd4,
      ORD_ZYX = 3'd5
   } walk_ord_e;

   localparam int N_AXES = 3;

   // Axis numbering: 0 = X, 1 = Y, 2 = Z.
   // Result packs {slowest, middle, fastest}, two bits per axis.
   function automatic logic [5:0] axis_order(input logic [2:0] code);
      logic [5:0] r;
      case (code)
         ORD_XYZ: r = {2'd2, 2'd1, 2'd0};
         ORD_XZY: r = {2'd1, 2'd2, 2'd0};
         ORD_YXZ: r = {2'd2, 2'd0, 2'd1};
         ORD_YZX: r = {2'd0, 2'd2, 2'd1};
         ORD_ZXY: r = {2'd1, 2'd0, 2'd2};
         ORD_ZYX: r = {2'd0, 2'd1, 2'd2};
         default: r = {2'd2, 2'd1, 2'd0};
      endcase
      return r;
   endfunction

   function automatic logic code_legal(input logic [2:0] code);
      return (code <= 3'd5);
   endfunction

endpackage

// File: rtl/idx_remap_decode.sv
module idx_remap_decode #(
   parameter int CFG_W  = 32,
   parameter int LANE_W = 8,
   localparam int DIM_W = LANE_W - 1,
   localparam int CNT_W = DIM_W + 1
) (
   input  logic [CFG_W-1:0] cfg_word,
   output logic [CNT_W-1:0] size_x,
   output logic [CNT_W-1:0] size_y,
   output logic [CNT_W-1:0] size_z,
   output logic [2:0]       ord_code,
   output logic [2:0]       flags,
   output logic             legal
);
   import idx_remap_pkg::*;

   logic [CNT_W-1:0] sz [N_AXES];

   for (genvar g = 0; g < N_AXES; g++) begin : g_lane
      // size field in the low part of each lane, flag in its top bit
      assign sz[g]    = CNT_W'(cfg_word[g*LANE_W +: DIM_W]) + CNT_W'(1);
      assign flags[g] = cfg_word[g*LANE_W + LANE_W - 1];
   end

   assign size_x   = sz[0];
   assign size_y   = sz[1];
   assign size_z   = sz[2];
   assign ord_code = cfg_word[N_AXES*LANE_W +: 3];
   assign legal    = code_legal(ord_code);

endmodule

// File: rtl/idx_remap_walker.sv
module idx_remap_walker #(
   parameter int DEPTH   = 128,
   parameter int CNT_W   = 8,
   parameter int ENTRY_W = 8,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int LIN_W  = 3 * CNT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [CNT_W-1:0]   size_x,
   input  logic [CNT_W-1:0]   size_y,
   input  logic [CNT_W-1:0]   size_z,
   input  logic [2:0]         ord_code,
   output logic               busy,
   output logic               wr_en,
   output logic [IDX_W-1:0]   wr_addr,
   output logic [ENTRY_W-1:0] wr_data,
   output logic               last
);
   import idx_remap_pkg::*;

   logic [CNT_W-1:0] lim_q [N_AXES];
   logic [CNT_W-1:0] cnt_q [N_AXES];
   logic [CNT_W-1:0] cnt_d [N_AXES];
   logic [1:0]       ord_q [N_AXES];
   logic [5:0]       ord_pack;
   logic [IDX_W-1:0] step_q;
   logic             busy_q;
   logic [LIN_W-1:0] lin;

   assign ord_pack = axis_order(ord_code);

   // carry chain through the axes in the selected order
   always_comb begin
      logic       carry;
      logic [1:0] ax;
      carry = 1'b1;
      ax    = 2'd0;
      for (int a = 0; a < N_AXES; a++) cnt_d[a] = cnt_q[a];
      for (int j = 0; j < N_AXES; j++) begin
         ax = ord_q[j];
         if (carry) begin
            if (cnt_q[ax] + CNT_W'(1) == lim_q[ax]) begin
               cnt_d[ax] = '0;
            end else begin
               cnt_d[ax] = cnt_q[ax] + CNT_W'(1);
               carry     = 1'b0;
            end
         end
      end
   end

   assign lin = LIN_W'(cnt_q[0])
              + LIN_W'(cnt_q[1]) * LIN_W'(lim_q[0])
              + LIN_W'(cnt_q[2]) * LIN_W'(lim_q[0]) * LIN_W'(lim_q[1]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         step_q <= '0;
         for (int a = 0; a < N_AXES; a++) begin
            lim_q[a] <= CNT_W'(1);
            cnt_q[a] <= '0;
            ord_q[a] <= 2'(a);
         end
      end else if (start && !busy_q) begin
         busy_q   <= 1'b1;
         step_q   <= '0;
         lim_q[0] <= size_x;
         lim_q[1] <= size_y;
         lim_q[2] <= size_z;
         for (int a = 0; a < N_AXES; a++) begin
            cnt_q[a] <= '0;
            ord_q[a] <= ord_pack[2*a +: 2];
         end
      end else if (busy_q) begin
         step_q <= step_q + IDX_W'(1);
         for (int a = 0; a < N_AXES; a++) cnt_q[a] <= cnt_d[a];
         if (step_q == IDX_W'(DEPTH - 1)) busy_q <= 1'b0;
      end
   end

   assign busy    = busy_q;
   assign wr_en   = busy_q;
   assign wr_addr = step_q;
   assign wr_data = lin[ENTRY_W-1:0];
   assign last    = busy_q && (step_q == IDX_W'(DEPTH - 1));

endmodule

// File: rtl/idx_remap_bank.sv
module idx_remap_bank #(
   parameter int DEPTH      = 128,
   parameter int ENTRY_W    = 8,
   parameter bit DOUBLE_BUF = 1'b1,
   localparam int IDX_W     = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_addr,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic               swap,
   input  logic [IDX_W-1:0]   rd_addr,
   output logic [ENTRY_W-1:0] rd_data
);

   if (DOUBLE_BUF) begin : g_pingpong
      logic [ENTRY_W-1:0] mem [2][DEPTH];
      logic               act_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            act_q   <= 1'b0;
            rd_data <= '0;
            for (int b = 0; b < 2; b++)
               for (int i = 0; i < DEPTH; i++) mem[b][i] <= '0;
         end else begin
            rd_data <= mem[act_q][rd_addr];
            if (wr_en) mem[~act_q][wr_addr] <= wr_data;
            if (swap) act_q <= ~act_q;
         end
      end
   end else begin : g_single
      logic [ENTRY_W-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rd_data <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else begin
            rd_data <= mem[rd_addr];
            if (wr_en) mem[wr_addr] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/idx_remap_gen.sv
module idx_remap_gen #(
   parameter int DEPTH      = 128,
   parameter int ENTRY_W    = 8,
   parameter int LANE_W     = 8,
   parameter int CFG_W      = 32,
   parameter bit DOUBLE_BUF = 1'b1,
   localparam int IDX_W     = $clog2(DEPTH),
   localparam int CNT_W     = LANE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [CFG_W-1:0]   cfg_data,
   input  logic [IDX_W-1:0]   lk_idx,
   output logic [ENTRY_W-1:0] lk_data,
   output logic               busy,
   output logic               cfg_err,
   output logic [2:0]         offs_flags
);

   if (DEPTH != (1 << IDX_W)) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (CFG_W < 3 * LANE_W + 3) begin : g_bad_cfg
      $error("CFG_W too narrow for three lanes and the order code");
   end
   if (LANE_W < 2) begin : g_bad_lane
      $error("LANE_W must be at least 2");
   end

   logic [CNT_W-1:0]   sx, sy, sz;
   logic [2:0]         code;
   logic [2:0]         flags;
   logic               legal;
   logic               accept;
   logic               start;
   logic               wr_en;
   logic [IDX_W-1:0]   wr_addr;
   logic [ENTRY_W-1:0] wr_data;
   logic               last;
   logic               err_q;
   logic [2:0]         offs_q;

   idx_remap_decode #(.CFG_W(CFG_W), .LANE_W(LANE_W)) u_dec (
      .cfg_word (cfg_data),
      .size_x   (sx),
      .size_y   (sy),
      .size_z   (sz),
      .ord_code (code),
      .flags    (flags),
      .legal    (legal)
   );

   assign accept = cfg_we && !busy;
   assign start  = accept && legal;

   idx_remap_walker #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ENTRY_W(ENTRY_W)) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .size_x   (sx),
      .size_y   (sy),
      .size_z   (sz),
      .ord_code (code),
      .busy     (busy),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .last     (last)
   );

   idx_remap_bank #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .DOUBLE_BUF(DOUBLE_BUF)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .swap    (last),
      .rd_addr (lk_idx),
      .rd_data (lk_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q  <= 1'b0;
         offs_q <= '0;
      end else begin
         err_q <= accept && !legal;
         if (start) offs_q <= flags;
      end
   end

   assign cfg_err    = err_q;
   assign offs_flags = offs_q;

endmodule

// File: rtl/idx_remap_chk.sv
module idx_remap_chk #(
   parameter int DEPTH      = 128,
   parameter int ENTRY_W    = 8,
   parameter int LANE_W     = 8,
   parameter int CFG_W      = 32,
   parameter bit DOUBLE_BUF = 1'b1,
   localparam int IDX_W     = $clog2(DEPTH)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cfg_we,
   input logic [CFG_W-1:0]   cfg_data,
   input logic [IDX_W-1:0]   lk_idx,
   input logic [ENTRY_W-1:0] lk_data,
   input logic               busy,
   input logic               cfg_err,
   input logic [2:0]         offs_flags
);

   logic [IDX_W:0] run_cnt;
   logic           code_ok;

   assign code_ok = (cfg_data[3*LANE_W +: 3] < 3'd6);

   always_ff @(posedge clk) begin
      if (!rst_n)    run_cnt <= '0;
      else if (busy) run_cnt <= run_cnt + (IDX_W+1)'(1);
      else           run_cnt <= '0;
   end

   // R7: fill starts on a legal idle write and lasts DEPTH cycles
   a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cfg_we && code_ok) |=> busy);
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && run_cnt < (IDX_W+1)'(DEPTH - 1)) |=> busy);
   a_r7_end: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && run_cnt == (IDX_W+1)'(DEPTH - 1)) |=> !busy);

   // R5: illegal code gives a single error pulse and changes nothing
   a_r5_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cfg_we && !code_ok) |=> (cfg_err && !busy && $stable(offs_flags)));
   a_r5_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> !cfg_err);

   // R10: writes during a fill are dropped
   a_r10_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg_we) |=> (!cfg_err && $stable(offs_flags)));

   // R8: the visible table does not move during a fill
   if (DOUBLE_BUF) begin : g_hold
      a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (busy && $past(busy) && $stable(lk_idx)) |=> $stable(lk_data));
   end

endmodule

bind idx_remap_gen idx_remap_chk #(
   .DEPTH(DEPTH), .ENTRY_W(ENTRY_W), .LANE_W(LANE_W),
   .CFG_W(CFG_W), .DOUBLE_BUF(DOUBLE_BUF)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_data   (cfg_data),
   .lk_idx     (lk_idx),
   .lk_data    (lk_data),
   .busy       (busy),
   .cfg_err    (cfg_err),
   .offs_flags (offs_flags)
);

// File: tb/sim_idx_remap_gen.sv
`timescale 1ns/1ps
module sim_idx_remap_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_data = '0;
   logic [6:0]  lk_idx = '0;
   logic [7:0]  lk_data;
   logic        busy;
   logic        cfg_err;
   logic [2:0]  offs_flags;

   int  total = 0;
   int  bad   = 0;
   bit  finished = 1'b0;

   logic [7:0] exp_tab [128];
   logic [7:0] old_tab [128];
   logic [2:0] exp_offs = 3'b000;

   always #2.5 clk = ~clk;

   idx_remap_gen u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
      .lk_idx(lk_idx), .lk_data(lk_data), .busy(busy),
      .cfg_err(cfg_err), .offs_flags(offs_flags)
   );

   task automatic check(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic logic [31:0] mk(input int xs, input int ys, input int zs,
                                      input int code, input logic [2:0] fl);
      logic [31:0] w;
      w = '0;
      w[6:0]   = 7'(xs - 1);
      w[14:8]  = 7'(ys - 1);
      w[22:16] = 7'(zs - 1);
      w[7]     = fl[0];
      w[15]    = fl[1];
      w[23]    = fl[2];
      w[26:24] = 3'(code);
      return w;
   endfunction

   // expected table from the requirements (R1..R4)
   task automatic build_model(input logic [31:0] w);
      int lim [3];
      int pos [3];
      int ord [3];
      int lin;
      lim[0] = int'(w[6:0]) + 1;
      lim[1] = int'(w[14:8]) + 1;
      lim[2] = int'(w[22:16]) + 1;
      case (w[26:24])
         3'd0: begin ord[0] = 0; ord[1] = 1; ord[2] = 2; end
         3'd1: begin ord[0] = 0; ord[1] = 2; ord[2] = 1; end
         3'd2: begin ord[0] = 1; ord[1] = 0; ord[2] = 2; end
         3'd3: begin ord[0] = 1; ord[1] = 2; ord[2] = 0; end
         3'd4: begin ord[0] = 2; ord[1] = 0; ord[2] = 1; end
         default: begin ord[0] = 2; ord[1] = 1; ord[2] = 0; end
      endcase
      for (int a = 0; a < 3; a++) pos[a] = 0;
      for (int k = 0; k < 128; k++) begin
         lin = pos[0] + pos[1] * lim[0] + pos[2] * lim[0] * lim[1];
         exp_tab[k] = 8'(lin);
         for (int j = 0; j < 3; j++) begin
            if (pos[ord[j]] + 1 == lim[ord[j]]) pos[ord[j]] = 0;
            else begin
               pos[ord[j]] = pos[ord[j]] + 1;
               break;
            end
         end
      end
   endtask

   task automatic do_write(input logic [31:0] w);
      @(negedge clk);
      cfg_we   = 1'b1;
      cfg_data = w;
      @(negedge clk);
      cfg_we   = 1'b0;
   endtask

   // called one negedge after the write edge; counts busy cycles (R7)
   task automatic wait_fill(input bit count_it);
      int n;
      n = 0;
      while (busy && n < 1000) begin
         n++;
         @(negedge clk);
      end
      if (count_it) check(n == 128, "R7 busy length", n, 128);
   endtask

   task automatic read_all(input string req);
      for (int i = 0; i < 128; i++) begin
         lk_idx = 7'(i);
         @(negedge clk);
         check(lk_data == exp_tab[i], req, int'(lk_data), int'(exp_tab[i]));
      end
   endtask

   task automatic t_reset;
      check(busy == 1'b0, "R9 busy after reset", int'(busy), 0);
      check(cfg_err == 1'b0, "R9 err after reset", int'(cfg_err), 0);
      check(offs_flags == 3'b000, "R9 offs after reset", int'(offs_flags), 0);
      for (int i = 0; i < 128; i++) exp_tab[i] = 8'd0;
      read_all("R9 table zero after reset");
   endtask

   task automatic t_shape(input logic [31:0] w, input string req);
      build_model(w);
      exp_offs = {w[23], w[15], w[7]};
      do_write(w);
      check(busy == 1'b1, "R7 busy rises", int'(busy), 1);
      check(offs_flags == exp_offs, "R6 offset flags", int'(offs_flags), int'(exp_offs));
      wait_fill(1'b1);
      read_all(req);
   endtask

   task automatic t_illegal(input int code);
      logic [31:0] w;
      w = mk(3, 3, 3, code, 3'b101);
      do_write(w);
      check(cfg_err == 1'b1, "R5 error pulse high", int'(cfg_err), 1);
      check(busy == 1'b0, "R5 no fill on illegal code", int'(busy), 0);
      @(negedge clk);
      check(cfg_err == 1'b0, "R5 error pulse one cycle", int'(cfg_err), 0);
      check(offs_flags == exp_offs, "R5 offsets unchanged", int'(offs_flags), int'(exp_offs));
      read_all("R5 table unchanged");
   endtask

   task automatic t_busy_ignore;
      logic [31:0] wa, wb;
      wa = mk(3, 2, 5, 2, 3'b010);
      wb = mk(4, 4, 4, 7, 3'b101);
      build_model(wa);
      exp_offs = {wa[23], wa[15], wa[7]};
      do_write(wa);
      repeat (5) @(negedge clk);
      do_write(wb);
      check(cfg_err == 1'b0, "R10 no error while busy", int'(cfg_err), 0);
      do_write(mk(8, 8, 2, 0, 3'b111));
      check(offs_flags == exp_offs, "R10 offsets kept", int'(offs_flags), int'(exp_offs));
      wait_fill(1'b0);
      read_all("R10 table from first write");
   endtask

   task automatic t_lookup_busy;
      logic [31:0] w;
      for (int i = 0; i < 128; i++) old_tab[i] = exp_tab[i];
      w = mk(2, 7, 3, 3, 3'b001);
      build_model(w);
      exp_offs = {w[23], w[15], w[7]};
      do_write(w);
      for (int i = 0; i < 12; i++) begin
         lk_idx = 7'(i * 11);
         @(negedge clk);
         check(busy == 1'b1 && lk_data == old_tab[i * 11], "R8 old table during fill",
               int'(lk_data), int'(old_tab[i * 11]));
      end
      wait_fill(1'b0);
      read_all("R8 new table after fill");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_shape(mk(4, 4, 8, 0, 3'b001), "R2 R3 order 0 identity");
      t_shape(mk(3, 5, 2, 5, 3'b110), "R3 R4 order 5 wrap");
      t_shape(mk(2, 3, 4, 3, 3'b010), "R3 R4 order 3");
      t_shape(mk(5, 2, 3, 1, 3'b100), "R3 R4 order 1");
      t_shape(mk(3, 4, 2, 2, 3'b000), "R3 R4 order 2");
      t_shape(mk(6, 5, 100, 4, 3'b111), "R2 R3 order 4 truncation");
      t_shape(mk(1, 1, 1, 0, 3'b011), "R1 sizes of one");
      t_shape(mk(128, 1, 1, 0, 3'b000), "R1 size 128");
      t_shape(mk(7, 128, 128, 2, 3'b100), "R1 R2 large sizes");
      t_illegal(6);
      t_illegal(7);
      t_busy_ignore();
      t_lookup_busy();
      // R11: back-to-back lookups, each one edge later
      lk_idx = 7'd3;
      @(negedge clk);
      lk_idx = 7'd4;
      check(lk_data == exp_tab[3], "R11 latency first", int'(lk_data), int'(exp_tab[3]));
      @(negedge clk);
      check(lk_data == exp_tab[4], "R11 latency second", int'(lk_data), int'(exp_tab[4]));
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule